// File: doc/BRIEF.md
# Open-Grant Queue Selector

This block lives inside one input module of a three-stage buffered switch fabric. The input module holds N*K virtual output queues, one per destination port, where K is the number of output modules and N is the number of ports on each output module. Queue index v stands for port h of output module j, with v = h*K + j. When an open grant naming output module j arrives, the block searches only the N queues that lead to module j. It picks the first one that holds a cell and that the earlier matching phase of the same slot has not already taken. The chosen queue sends its cell in the following slot.

Each output module has its own round-robin pointer over the port numbers. A search for module j starts at the port held in that module's pointer and wraps around. The pointer moves only when a queue is actually chosen, so the modules rotate independently of one another. The decision is combinational from the grant inputs and is registered once, so the result appears one clock after the grant. If the grant is absent or names no valid module, no queue is chosen. If no candidate is eligible, no queue is chosen either, and no cell may leave without a grant.

Top module: `og_queue_selector`

## Requirements
- R1: A selected queue index always equals h*K + j, where j is the output module named by the open grant and h is a port number in 0..N-1.
- R2: The search for module j starts at port ptr(j) and goes through the ports in ascending order, wrapping from N-1 to 0. It selects the first port whose queue has its nonempty bit set and its matched bit clear.
- R3: A queue whose matched bit is set is never selected, even when its nonempty bit is set.
- R4: When no candidate queue of the granted module is eligible, sel_valid is 0 and sel_queue is 0.
- R5: When og_valid is 0, or og_mod is K or greater, nothing is selected and no pointer changes.
- R6: After a selection at port h for module j, ptr(j) becomes (h+1) mod N. The pointers of all other modules keep their values, and no pointer moves without a selection.
- R7: During and right after reset, sel_valid and sel_queue are 0 and every pointer is 0.
- R8: The result for a grant presented before a clock edge appears on sel_valid and sel_queue after that edge and holds for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nonempty | input | N*K | Bit v set: queue v holds a cell |
| matched | input | N*K | Bit v set: queue v was taken earlier in this slot |
| og_valid | input | 1 | An open grant is present this cycle |
| og_mod | input | clog2(K) | Output module named by the open grant |
| sel_valid | output | 1 | A queue was selected on the last edge |
| sel_queue | output | clog2(N*K) | Index of the selected queue, 0 when none |

## Verification
The bench uses K = 3 and N = 3, so there are nine queues. At these values the interleaved index layout is easy to check: for example, a grant for module 2 that picks port 2 gives queue 8. Because N is not a power of two, the pointer has to wrap from 2 back to 0 by its own logic rather than by an overflowing counter. Also, a 2-bit og_mod can carry the value 3, which tests the rejection of a module number that is out of range.

// File: rtl/og_queue_selector.sv
module og_queue_selector #(
  parameter int K = 3,
  parameter int N = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N*K-1:0]                          nonempty,
  input  logic [N*K-1:0]                          matched,
  input  logic                                    og_valid,
  input  logic [((K > 1) ? $clog2(K) : 1)-1:0]    og_mod,
  output logic                                    sel_valid,
  output logic [((N*K > 1) ? $clog2(N*K) : 1)-1:0] sel_queue
);
  localparam int Q  = N * K;
  localparam int QW = (Q > 1) ? $clog2(Q) : 1;
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [K-1:0][PW-1:0] ptr;
  logic [Q-1:0]         elig;
  logic                 grant_ok;
  logic                 hit;
  logic [PW-1:0]        hit_port;
  logic [QW-1:0]        hit_q;

  assign elig     = nonempty & ~matched;
  assign grant_ok = og_valid && (int'(og_mod) < K);
  assign hit_q    = QW'(int'(hit_port) * K + int'(og_mod));

  always_comb begin
    int h;
    hit      = 1'b0;
    hit_port = '0;
    h        = 0;
    if (grant_ok) begin
      for (int o = 0; o < N; o++) begin
        h = (int'(ptr[og_mod]) + o) % N;
        if (!hit && elig[h*K + int'(og_mod)]) begin
          hit      = 1'b1;
          hit_port = PW'(h);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_queue <= '0;
      ptr       <= '0;
    end else begin
      sel_valid <= hit;
      sel_queue <= hit ? hit_q : '0;
      if (hit)
        ptr[og_mod] <= (int'(hit_port) == N - 1) ? '0 : PW'(int'(hit_port) + 1);
    end
  end

  // R1: chosen queue belongs to the granted module
  p_mod_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (int'(sel_queue) % K) == int'($past(og_mod)));

  // R3: chosen queue was nonempty and not already matched
  p_elig_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((($past(nonempty) & ~$past(matched)) >> sel_queue) & Q'(1)) != '0);

  // R4: nothing eligible gives no selection
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (og_valid && (nonempty & ~matched) == '0) |=> (!sel_valid && sel_queue == '0));

  // R5: no grant gives no selection
  p_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !og_valid |=> !sel_valid);

  // R6: pointers hold when nothing was selected
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> $stable(ptr));
endmodule

// File: tb/tb_og_queue_selector.sv
module tb_og_queue_selector;
  localparam int K = 3;
  localparam int N = 3;
  localparam int Q = N * K;

  logic clk = 0;
  logic rst_n = 0;
  logic [Q-1:0] nonempty = '0;
  logic [Q-1:0] matched = '0;
  logic og_valid = 0;
  logic [1:0] og_mod = '0;
  logic sel_valid;
  logic [3:0] sel_queue;

  int errors = 0;
  int checks = 0;
  int ptr_m [K];
  bit exp_v;
  int exp_q;
  bit done = 0;

  always #2.5 clk = ~clk;

  og_queue_selector #(.K(K), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .nonempty(nonempty), .matched(matched),
    .og_valid(og_valid), .og_mod(og_mod), .sel_valid(sel_valid), .sel_queue(sel_queue));

  task automatic check(string tag);
    checks++;
    if (sel_valid !== exp_v || int'(sel_queue) !== exp_q) begin
      errors++;
      $display("FAIL %s: got valid=%0b queue=%0d, expected valid=%0b queue=%0d",
               tag, sel_valid, sel_queue, exp_v, exp_q);
    end
  endtask

  task automatic step(bit v, int m, logic [Q-1:0] ne, logic [Q-1:0] mt, string tag);
    og_valid = v; og_mod = 2'(m); nonempty = ne; matched = mt;
    @(posedge clk);
    exp_v = 0; exp_q = 0;
    if (v && m < K) begin
      for (int o = 0; o < N; o++) begin
        int h = (ptr_m[m] + o) % N;
        if (!exp_v && ne[h*K+m] && !mt[h*K+m]) begin
          exp_v = 1; exp_q = h*K + m;
          ptr_m[m] = (h + 1) % N;
        end
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(5 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < K; i++) ptr_m[i] = 0;
    repeat (3) @(negedge clk);
    exp_v = 0; exp_q = 0;
    check("R7 reset");
    rst_n = 1;
    @(negedge clk);
    check("R7 after reset");
    // R1: module 2, only port 2 holds a cell -> queue 8; R6 wrap back to 0
    step(1, 2, 9'b1_0000_0000, '0, "R1 queue 8");
    step(1, 2, 9'b1_0010_0100, '0, "R6 wrap ptr2 to 0");
    step(0, 0, '0, '0, "R8 one-cycle pulse");
    // R2: rotation over module 0
    step(1, 0, '1, '0, "R2 first q0");
    step(1, 0, '1, '0, "R2 then q3");
    step(1, 0, '1, '0, "R2 then q6");
    step(1, 0, '1, '0, "R2 wrap q0");
    // R3: matched excluded
    step(1, 1, '1, 9'b0_0001_0010, "R3 skip matched");
    // R4: none eligible
    step(1, 1, 9'b1_0110_1101, '0, "R4 no candidate");
    step(1, 2, '1, 9'b1_0010_0100, "R4 all matched");
    // R5: no grant / bad module, pointer unchanged afterwards
    step(0, 0, '1, '0, "R5 no grant");
    step(1, 3, '1, '0, "R5 module out of range");
    step(1, 0, '1, '0, "R5 ptr0 unchanged");
    // R6: independence of module pointers
    step(1, 1, '1, '0, "R6 module1 ptr");
    step(1, 2, '1, '0, "R6 module2 ptr");
    seed = 32'h1ace;
    for (int c = 0; c < 400; c++) begin
      logic [Q-1:0] ne, mt;
      seed = seed * 1103515245 + 12345; ne = Q'(seed >>> 7);
      seed = seed * 1103515245 + 12345; mt = Q'(seed >>> 9) & Q'(seed >>> 3);
      seed = seed * 1103515245 + 12345;
      step(((seed >>> 5) & 7) != 0, (seed >>> 11) & 3, ne, mt, "R2 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule